// File: doc/BRIEF.md
# Symmetric Dual-Channel PWM Timer

This block is an 8-bit timer that counts up from 0 to 255 and then back down to 0. It advances only on a clock-enable pulse from its own prescaler, which divides the system clock by 1, 8, 64, 256 or 1024, or stops the timer. One full up-and-down period is 510 timer steps long. Two compare channels, A and B, compare the count with their own compare value. From that they produce a pulse waveform that is centred on the bottom of the count. Channel A also has a toggle mode.

Software writes compare values into a holding register. A new value takes effect only when the counter reaches 255, so a period never mixes old and new values. At 255 every PWM output is forced to the level an upward match produces, even if no match occurred. This covers two cases: a counter that was loaded above the compare value, and a compare value that moved away from 255. In both cases the waveform stays symmetric around the bottom. A one-cycle pulse and a sticky flag mark each arrival at 0. A load port lets the counter be placed at any value.

Top module: `sym_pwm_timer`

## Requirements
- R1: The count runs 0,1,…,255,254,…,1,0 with each step of exactly one. 255 and 0 are each reached once per period, and a period is 510 timer steps.
- R2: `clk_sel_i` chooses the step rate: 1 steps every clock, 2 every 8, 3 every 64, 4 every 256 and 5 every 1024. Values 0, 6 and 7 stop the timer, which then holds its count and outputs.
- R3: Mode 2 (`mode_x_i`=2) is non-inverted PWM. The output goes low when the count reaches the compare value C while rising, and high when it reaches C while falling. For 0<C<255 the output is high for 2·C steps of each period.
- R4: Mode 3 is inverted PWM, the complement of mode 2. The output is high for 510−2·C steps.
- R5: In mode 2, C=0 keeps the output low and C=255 keeps it high. Mode 3 gives the opposite levels.
- R6: When the count reaches 255 with 0<C<255, a PWM output takes the level of an upward match. This happens even when no match was seen, for example after a load above C, or when C has just changed from 255.
- R7: Channel A in mode 1 with `toggle_a_en_i`=1 inverts its output each time the count reaches C. Channel B has no toggle. Mode 0, and mode 1 without toggle, drive the output low.
- R8: A compare write goes to a holding register. The active compare value takes the held value only when the count reaches 255.
- R9: `load_en_i` puts `load_val_i` into the count on the next clock. The load overrides a step, keeps the direction and does not change the outputs.
- R10: `tov_pulse_o` is high for one cycle, in the cycle where the count has just stepped to 0. `tov_flag_o` is set by that pulse and stays set until `tov_clr_i` is 1. If both happen in the same cycle, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel_i | input | 3 | Prescaler select (0/6/7 stop; 1..5 divide by 1,8,64,256,1024) |
| load_en_i | input | 1 | Load the count from `load_val_i` |
| load_val_i | input | 8 | Value to load |
| cmp_a_we_i | input | 1 | Write strobe for the channel A holding register |
| cmp_a_wdata_i | input | 8 | Channel A compare write data |
| cmp_b_we_i | input | 1 | Write strobe for the channel B holding register |
| cmp_b_wdata_i | input | 8 | Channel B compare write data |
| mode_a_i | input | 2 | Channel A output mode (0 off, 1 toggle, 2 non-inverted, 3 inverted) |
| mode_b_i | input | 2 | Channel B output mode (0/1 off, 2 non-inverted, 3 inverted) |
| toggle_a_en_i | input | 1 | Enables the mode 1 toggle on channel A |
| tov_clr_i | input | 1 | Write-one-to-clear for the bottom flag |
| count_o | output | 8 | Current count |
| wave_a_o | output | 1 | Channel A waveform |
| wave_b_o | output | 1 | Channel B waveform |
| tov_pulse_o | output | 1 | One-cycle pulse on reaching 0 |
| tov_flag_o | output | 1 | Sticky bottom flag |

## Verification
The compare value is swept in steps of 17 from 0 to 255, plus 1 and 254. Channel A runs non-inverted and channel B inverted. In every cycle of a full period, each output is checked against the level worked out from the count and the direction of the last step. The total high time is also checked against 2·C, which separates a wrong match direction from a wrong duty. Separate cases then check that the level is forced at 255: once after a load above C with the output still high, and once after C moves away from 255. A compare write in the middle of a period must not take effect before 255. The prescaler check measures the number of clocks between count changes for every divider.

// File: rtl/sym_pwm_pkg.sv
// Shared types for the symmetric PWM timer.
// Assumes: the mode encoding is decoded identically by every channel.
package sym_pwm_pkg;
    typedef enum logic [1:0] {
        OUT_OFF    = 2'd0,
        OUT_TOGGLE = 2'd1,
        OUT_PWM    = 2'd2,
        OUT_PWMINV = 2'd3
    } out_mode_e;
endpackage

// File: rtl/sym_pwm_prescaler.sv
// Clock-enable generator: emits one-cycle ticks at clk/1, /8, /64, /256
// or /1024 according to sel_i; other select values stop it.
// Assumes: PRE_W is at least 10 so the largest divider fits.
module sym_pwm_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel_i,
    output logic       tick_o
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             run;

    // select the divider mask; run is low for stop codes
    always_comb begin
        run  = 1'b1;
        case (sel_i)
            3'd1:    mask = '0;
            3'd2:    mask = PRE_W'(7);
            3'd3:    mask = PRE_W'(63);
            3'd4:    mask = PRE_W'(255);
            3'd5:    mask = PRE_W'(1023);
            default: begin mask = '0; run = 1'b0; end
        endcase
    end

    // free-running divider, parked at zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_q <= '0;
        else                pre_q <= pre_q + PRE_W'(1);
    end

    assign tick_o = run && ((pre_q & mask) == mask);

    assert_stop_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd0 || sel_i == 3'd6 || sel_i == 3'd7) |-> !tick_o);
    assert_div1_every_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'd1) |-> tick_o);
endmodule

// File: rtl/sym_pwm_counter.sv
// Up/down counter that bounces between 0 and the all-ones top value.
// Presents the next value and step direction so channels update in step.
// Assumes: load_en_i has priority over tick_i; a load keeps the direction.
module sym_pwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_en_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] nxt_o,
    output logic             step_o,
    output logic             step_up_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] count_q;
    logic             up_q;
    logic [CNT_W-1:0] nxt;
    logic             nxt_up;

    // next count and direction, turning at both ends
    always_comb begin
        if (count_q == TOP) begin
            nxt    = TOP - CNT_W'(1);
            nxt_up = 1'b0;
        end else if (count_q == '0) begin
            nxt    = CNT_W'(1);
            nxt_up = 1'b1;
        end else begin
            nxt    = up_q ? count_q + CNT_W'(1) : count_q - CNT_W'(1);
            nxt_up = up_q;
        end
        if (nxt == TOP)      nxt_up = 1'b0;
        else if (nxt == '0)  nxt_up = 1'b1;
    end

    // count register with load priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            up_q    <= 1'b1;
        end else if (load_en_i) begin
            count_q <= load_val_i;
        end else if (tick_i) begin
            count_q <= nxt;
            up_q    <= nxt_up;
        end
    end

    assign count_o   = count_q;
    assign nxt_o     = nxt;
    assign step_o    = tick_i && !load_en_i;
    assign step_up_o = nxt > count_q;

    assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_en_i) |=>
            (count_q == $past(count_q) + CNT_W'(1)) || (count_q == $past(count_q) - CNT_W'(1)));
    assert_turn_at_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_en_i && count_q == TOP) |=> count_q == TOP - CNT_W'(1));
    assert_turn_at_bottom_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_en_i && count_q == '0) |=> count_q == CNT_W'(1));
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_en_i) |=> $stable(count_q));
    assert_load_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_i |=> count_q == $past(load_val_i));
endmodule

// File: rtl/sym_pwm_channel.sv
// One compare channel: holding and active compare registers plus the
// waveform register for PWM, inverted PWM and (optionally) toggle modes.
// Assumes: step_i/nxt_i/step_up_i describe the counter move on this edge.
module sym_pwm_channel
    import sym_pwm_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter bit HAS_TOGGLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             step_up_i,
    input  logic [CNT_W-1:0] nxt_i,
    input  logic [1:0]       mode_i,
    input  logic             toggle_en_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic             wave_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] eff;
    logic             lvl_q;
    logic             lvl_d;
    logic             at_top;
    logic             pwm_mode;
    logic             tgl_mode;
    logic             up_lvl;

    assign at_top   = step_i && (nxt_i == TOP);
    assign eff      = at_top ? hold_q : act_q;
    assign pwm_mode = (mode_i == OUT_PWM) || (mode_i == OUT_PWMINV);
    assign up_lvl   = (mode_i == OUT_PWMINV);

    generate
        if (HAS_TOGGLE) begin : g_tgl
            assign tgl_mode = (mode_i == OUT_TOGGLE) && toggle_en_i;
        end else begin : g_no_tgl
            assign tgl_mode = 1'b0 && toggle_en_i;
        end
    endgenerate

    // holding register written by the host
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_q <= '0;
        else if (we_i) hold_q <= wdata_i;
    end

    // active compare copied from the holding register at top
    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= '0;
        else if (at_top) act_q <= hold_q;
    end

    // next waveform level from match, extremes and top forcing
    always_comb begin
        lvl_d = lvl_q;
        if (step_i && pwm_mode) begin
            if (eff == '0)            lvl_d = up_lvl;
            else if (eff == TOP)      lvl_d = !up_lvl;
            else if (nxt_i == TOP)    lvl_d = up_lvl;
            else if (nxt_i == eff)    lvl_d = step_up_i ? up_lvl : !up_lvl;
        end else if (step_i && tgl_mode) begin
            if (nxt_i == eff)         lvl_d = !lvl_q;
        end
    end

    // waveform register
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign wave_o = (pwm_mode || tgl_mode) ? lvl_q : 1'b0;

    assert_zero_cmp_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(step_i) && $past(mode_i) == OUT_PWM && mode_i == OUT_PWM && act_q == '0)
            |-> !wave_o);
    assert_top_cmp_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(step_i) && $past(mode_i) == OUT_PWM && mode_i == OUT_PWM && act_q == TOP)
            |-> wave_o);
    assert_top_forces_up_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(at_top) && $past(mode_i) == mode_i && mode_i[1] && act_q != '0 && act_q != TOP)
            |-> wave_o == mode_i[0]);
    assert_active_changes_at_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(at_top) |-> $stable(act_q));
    assert_off_mode_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OUT_OFF) |-> !wave_o);
endmodule

// File: rtl/sym_pwm_timer.sv
// Top level: prescaler, bouncing counter, two compare channels (A with
// toggle support) and the bottom pulse/flag.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module sym_pwm_timer #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel_i,
    input  logic             load_en_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             cmp_a_we_i,
    input  logic [CNT_W-1:0] cmp_a_wdata_i,
    input  logic             cmp_b_we_i,
    input  logic [CNT_W-1:0] cmp_b_wdata_i,
    input  logic [1:0]       mode_a_i,
    input  logic [1:0]       mode_b_i,
    input  logic             toggle_a_en_i,
    input  logic             tov_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wave_a_o,
    output logic             wave_b_o,
    output logic             tov_pulse_o,
    output logic             tov_flag_o
);
    logic             tick;
    logic             step;
    logic             step_up;
    logic [CNT_W-1:0] nxt;
    logic             hit_bottom;
    logic             pulse_q;
    logic             flag_q;

    sym_pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (clk_sel_i),
        .tick_o (tick)
    );

    sym_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_en_i  (load_en_i),
        .load_val_i (load_val_i),
        .count_o    (count_o),
        .nxt_o      (nxt),
        .step_o     (step),
        .step_up_o  (step_up)
    );

    sym_pwm_channel #(.CNT_W(CNT_W), .HAS_TOGGLE(1'b1)) u_ch_a (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step),
        .step_up_i   (step_up),
        .nxt_i       (nxt),
        .mode_i      (mode_a_i),
        .toggle_en_i (toggle_a_en_i),
        .we_i        (cmp_a_we_i),
        .wdata_i     (cmp_a_wdata_i),
        .wave_o      (wave_a_o)
    );

    sym_pwm_channel #(.CNT_W(CNT_W), .HAS_TOGGLE(1'b0)) u_ch_b (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step),
        .step_up_i   (step_up),
        .nxt_i       (nxt),
        .mode_i      (mode_b_i),
        .toggle_en_i (1'b0),
        .we_i        (cmp_b_we_i),
        .wdata_i     (cmp_b_wdata_i),
        .wave_o      (wave_b_o)
    );

    assign hit_bottom = step && (nxt == '0);

    // bottom pulse and sticky flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            pulse_q <= hit_bottom;
            if (hit_bottom)     flag_q <= 1'b1;
            else if (tov_clr_i) flag_q <= 1'b0;
        end
    end

    assign tov_pulse_o = pulse_q;
    assign tov_flag_o  = flag_q;

    assert_pulse_at_bottom_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tov_pulse_o |-> (count_o == '0));
    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tov_pulse_o |=> !tov_pulse_o);
    assert_flag_follows_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tov_pulse_o |-> tov_flag_o);
    assert_no_toggle_on_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b_i == 2'd1) |-> !wave_b_o);
endmodule

// File: tb/sym_pwm_timer_tb.sv
module sym_pwm_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel_i = 3'd0;
    logic       load_en_i = 1'b0;
    logic [7:0] load_val_i = 8'd0;
    logic       cmp_a_we_i = 1'b0;
    logic [7:0] cmp_a_wdata_i = 8'd0;
    logic       cmp_b_we_i = 1'b0;
    logic [7:0] cmp_b_wdata_i = 8'd0;
    logic [1:0] mode_a_i = 2'd0;
    logic [1:0] mode_b_i = 2'd0;
    logic       toggle_a_en_i = 1'b0;
    logic       tov_clr_i = 1'b0;
    logic [7:0] count_o;
    logic       wave_a_o, wave_b_o, tov_pulse_o, tov_flag_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sym_pwm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .clk_sel_i(clk_sel_i),
        .load_en_i(load_en_i), .load_val_i(load_val_i),
        .cmp_a_we_i(cmp_a_we_i), .cmp_a_wdata_i(cmp_a_wdata_i),
        .cmp_b_we_i(cmp_b_we_i), .cmp_b_wdata_i(cmp_b_wdata_i),
        .mode_a_i(mode_a_i), .mode_b_i(mode_b_i), .toggle_a_en_i(toggle_a_en_i),
        .tov_clr_i(tov_clr_i), .count_o(count_o), .wave_a_o(wave_a_o),
        .wave_b_o(wave_b_o), .tov_pulse_o(tov_pulse_o), .tov_flag_o(tov_flag_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            finish_run();
        end
    end

    task automatic wait_count(input int v);
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (count_o == v) return;
        end
    endtask

    task automatic write_cmp(input int a, input int b);
        cmp_a_we_i = 1'b1; cmp_a_wdata_i = 8'(a);
        cmp_b_we_i = 1'b1; cmp_b_wdata_i = 8'(b);
        @(negedge clk);
        cmp_a_we_i = 1'b0; cmp_b_we_i = 1'b0;
    endtask

    // expected non-inverted level from compare, count and last step direction
    function automatic bit exp_ni(input int c, input int v, input bit up);
        if (c == 0)   return 1'b0;
        if (c == 255) return 1'b1;
        if (v == 255) return 1'b0;
        return up ? (v < c) : (v <= c);
    endfunction

    initial begin
        int c, prev, err_a, err_b, hi_a, hi_b, n, pulses, tops, bots, bad_pulse, edges;
        bit up, last;
        int divs[4];
        int dv;
        divs[0] = 8; divs[1] = 64; divs[2] = 256; divs[3] = 1024;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(count_o == 0, "R1 reset count", count_o, 0);
        chk(!wave_a_o && !wave_b_o, "R7 reset waves", wave_a_o, 0);
        chk(!tov_flag_o && !tov_pulse_o, "R10 reset flag", tov_flag_o, 0);

        // R2: stopped timer holds
        repeat (40) @(negedge clk);
        chk(count_o == 0, "R2 select 0 holds count", count_o, 0);

        // R1 / R10: period length, end visits, bottom pulse
        clk_sel_i = 3'd1;
        wait_count(255);
        n = 0; tops = 0; bots = 0; pulses = 0; bad_pulse = 0;
        do begin
            @(negedge clk);
            n++;
            if (count_o == 255) tops++;
            if (count_o == 0) bots++;
            if (tov_pulse_o) begin
                pulses++;
                if (count_o != 0) bad_pulse++;
            end
        end while (count_o != 255 && n < 2000);
        chk(n == 510, "R1 period length", n, 510);
        chk(tops == 1 && bots == 1, "R1 one top and one bottom", tops * 10 + bots, 11);
        chk(pulses == 1 && bad_pulse == 0, "R10 one pulse at bottom", pulses, 1);
        chk(tov_flag_o, "R10 flag set", tov_flag_o, 1);

        // R3/R4/R5: compare sweep, A non-inverted, B inverted
        mode_a_i = 2'd2; mode_b_i = 2'd3;
        for (int k = 0; k < 18; k++) begin
            c = (k < 16) ? k * 17 : ((k == 16) ? 1 : 254);
            @(negedge clk);
            if (count_o == 254) @(negedge clk);
            write_cmp(c, c);
            wait_count(255);
            err_a = 0; err_b = 0; hi_a = 0; hi_b = 0; prev = 254;
            for (int i = 0; i < 510; i++) begin
                if (i > 0) @(negedge clk);
                up = (i == 0) ? 1'b1 : (int'(count_o) > prev);
                if (wave_a_o != exp_ni(c, count_o, up)) err_a++;
                if (wave_b_o != !exp_ni(c, count_o, up)) err_b++;
                if (wave_a_o) hi_a++;
                if (wave_b_o) hi_b++;
                prev = count_o;
            end
            if (c == 0 || c == 255) begin
                chk(err_a == 0 && err_b == 0, "R5 extreme compare levels", err_a + err_b, 0);
                chk(hi_a == 2 * c, "R5 extreme duty", hi_a, 2 * c);
            end else begin
                chk(err_a == 0, "R3 per-step level", err_a, 0);
                chk(err_b == 0, "R4 per-step inverted level", err_b, 0);
                chk(hi_a == 2 * c, "R3 high time", hi_a, 2 * c);
                chk(hi_b == 510 - 2 * c, "R4 high time", hi_b, 510 - 2 * c);
            end
        end

        // R6 / R8: leave 255 for 100 with write mid-period
        @(negedge clk);
        if (count_o == 254) @(negedge clk);
        write_cmp(255, 255);
        wait_count(255);
        wait_count(0);
        wait_count(200);
        write_cmp(100, 100);
        wait_count(254);
        chk(wave_a_o == 1'b1, "R8 old compare kept until top", wave_a_o, 1);
        @(negedge clk);
        chk(count_o == 255 && wave_a_o == 1'b0, "R6 forced level leaving 255", wave_a_o, 0);

        // R8: mid-period write does not act before top
        wait_count(0);
        wait_count(50);
        write_cmp(10, 100);
        wait_count(60);
        chk(wave_a_o == 1'b1, "R8 new compare deferred", wave_a_o, 1);
        wait_count(100);
        chk(wave_a_o == 1'b0, "R8 old match still active", wave_a_o, 0);

        // R6 / R9: load above compare misses the up match
        write_cmp(100, 100);
        wait_count(255);
        wait_count(0);
        wait_count(20);
        chk(wave_a_o == 1'b1, "R6 high before load", wave_a_o, 1);
        load_en_i = 1'b1; load_val_i = 8'd200;
        @(negedge clk);
        load_en_i = 1'b0;
        chk(count_o == 200, "R9 load value", count_o, 200);
        chk(wave_a_o == 1'b1, "R9 load leaves output", wave_a_o, 1);
        @(negedge clk);
        chk(count_o == 201, "R9 direction kept", count_o, 201);
        wait_count(254);
        chk(wave_a_o == 1'b1, "R6 held until top", wave_a_o, 1);
        @(negedge clk);
        chk(count_o == 255 && wave_a_o == 1'b0, "R6 missed match recovered", wave_a_o, 0);

        // R7: toggle on A, none on B
        mode_a_i = 2'd1; toggle_a_en_i = 1'b1; mode_b_i = 2'd1;
        wait_count(255);
        edges = 0; hi_b = 0; last = wave_a_o;
        for (int i = 0; i < 510; i++) begin
            @(negedge clk);
            if (wave_a_o != last) edges++;
            last = wave_a_o;
            if (wave_b_o) hi_b++;
        end
        chk(edges == 2, "R7 two toggles per period", edges, 2);
        chk(hi_b == 0, "R7 channel B mode 1 low", hi_b, 0);
        toggle_a_en_i = 1'b0;
        hi_a = 0;
        for (int i = 0; i < 510; i++) begin
            @(negedge clk);
            if (wave_a_o) hi_a++;
        end
        chk(hi_a == 0, "R7 mode 1 without toggle low", hi_a, 0);
        mode_a_i = 2'd0;
        @(negedge clk);
        chk(wave_a_o == 1'b0, "R7 mode 0 low", wave_a_o, 0);

        // R2: divider intervals
        for (int s = 0; s < 4; s++) begin
            clk_sel_i = 3'(s + 2);
            prev = count_o;
            for (int g = 0; g < 3000 && count_o == prev; g++) @(negedge clk);
            prev = count_o; dv = 0;
            for (int g = 0; g < 3000 && count_o == prev; g++) begin
                @(negedge clk);
                dv++;
            end
            chk(dv == divs[s], "R2 divider interval", dv, divs[s]);
        end
        clk_sel_i = 3'd6;
        mode_a_i = 2'd2;
        @(negedge clk);
        prev = count_o; last = wave_a_o; n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (count_o != prev || wave_a_o != last) n++;
        end
        chk(n == 0, "R2 select 6 stops", n, 0);

        // R10: write-one-to-clear and re-set
        clk_sel_i = 3'd1;
        wait_count(100);
        tov_clr_i = 1'b1;
        @(negedge clk);
        tov_clr_i = 1'b0;
        chk(tov_flag_o == 1'b0, "R10 flag cleared", tov_flag_o, 0);
        wait_count(0);
        chk(tov_flag_o == 1'b1 && tov_pulse_o == 1'b1, "R10 flag set at bottom", tov_flag_o, 1);
        @(negedge clk);
        chk(tov_pulse_o == 1'b0, "R10 pulse one cycle", tov_pulse_o, 0);

        finish_run();
    end
endmodule